// File: doc/BRIEF.md
# Telemetry Peak Capture and Snapshot Logger

This block sits behind the sensor front end of a compute module and turns a stream of telemetry samples into evidence that survives short bursts. Each channel (die temperature, a hotspot temperature, input voltage, input power and a key-rail voltage by default) keeps a running exponential average for control loops together with an extreme-value hold: the maximum for temperature and power channels, the minimum for voltage channels. A limit per channel raises a latched alert from the held extreme, so a single burst sample can never be averaged away before it is seen.

Fault flags, link error/retrain pulses and the current throttle level enter beside the samples. A new alert, a rising fault flag or any change of throttle level freezes a time-stamped snapshot of every channel's held extreme, the fault flags, the error count and the throttle level into a small circular log. The log is read oldest-first through a pop strobe; when it is full the oldest entry is discarded and a sticky overflow flag is raised. Current/power channels are expected to be strobed more often than temperature channels; each channel has its own sample strobe.

Top module: `tlm_snap_logger`

## Requirements
- R1: On the first strobed sample after reset a channel's average loads the sample; afterwards each strobed sample s updates avg to avg + floor((s - avg) / 2^SHIFT), visible on avg_o after the strobing edge; without a strobe avg_o holds.
- R2: Channels whose bit in MIN_MASK is 1 (default channels 2 and 4) hold the minimum sample since the last read and start at all ones; the others hold the maximum and start at zero.
- R3: A hold read (hold_rd_i with channel hold_sel_i) returns the held value on hold_o after the edge and restarts that channel's hold; a sample strobed on the same edge becomes the new hold; a channel number of NCH or above returns zero.
- R4: A maximum channel's alert sets when its hold exceeds limit_i, a minimum channel's when its hold is below limit_i; alerts stay set until alert_clr_i for that channel is given while the condition is absent.
- R5: A newly set alert, a 0-to-1 transition of any fault_i bit, or a change of lvl_i relative to the previous cycle writes one log entry on the following edge.
- R6: An entry holds, from most to least significant: a 16-bit timestamp equal to the number of clock edges since reset release that precede the write edge, all channel holds (channel 0 lowest), fault flags, error count and throttle level, all as they stood after the triggering edge.
- R7: Each cycle with err_evt_i high adds one to an 8-bit error count that saturates at 255; entries carry this count.
- R8: The log returns entries oldest-first; log_valid_o shows a non-empty log with the oldest entry on the log outputs; log_pop_i discards it; a pop on an empty log has no effect; log_count_o gives the occupancy.
- R9: A write to a full log without a pop on the same edge discards the oldest entry and sets log_ovf_o, which stays set until ovf_clr_i (a new drop on that edge keeps it set).
- R10: During reset averages, holds read data, alerts, log count and overflow are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_vld_i | input | NCH | Per-channel sample strobe |
| smp_i | input | NCH*DW | Samples, channel i at bits i*DW |
| limit_i | input | NCH*DW | Alert limits per channel |
| alert_clr_i | input | NCH | Per-channel alert clear |
| fault_i | input | NF | Fault flag levels |
| err_evt_i | input | 1 | Error/retrain event pulse |
| lvl_i | input | TW | Current throttle level |
| hold_rd_i | input | 1 | Hold read-and-restart strobe |
| hold_sel_i | input | SELW | Channel for hold read |
| log_pop_i | input | 1 | Discard oldest log entry |
| ovf_clr_i | input | 1 | Clear overflow flag |
| avg_o | output | NCH*DW | Channel averages |
| alert_o | output | NCH | Latched alerts |
| hold_o | output | DW | Hold read data |
| log_valid_o | output | 1 | Log not empty |
| log_count_o | output | CNTW | Log occupancy |
| log_ovf_o | output | 1 | Sticky overflow |
| log_ts_o | output | TSW | Oldest entry timestamp |
| log_hold_o | output | NCH*DW | Oldest entry channel holds |
| log_fault_o | output | NF | Oldest entry fault flags |
| log_err_o | output | CW | Oldest entry error count |
| log_lvl_o | output | TW | Oldest entry throttle level |

## Verification
A wrong average or hold register appears on avg_o one edge after the faulty update and on hold_o at the next read, and it also corrupts the held values copied into later log entries. A lost or spurious trigger shows as a wrong log_count_o two edges after the event, and a bad pointer or drop decision shows as a wrong oldest entry or overflow flag as soon as the log is read. The bench keeps a cycle model built from the requirements and compares every output every cycle, with directed runs for the seeding rule, clear-on-read, alert latching, counter saturation and overflow.

// File: rtl/tlm_pkg.sv
package tlm_pkg;
  typedef enum logic {
    KIND_PEAK = 1'b0,
    KIND_MIN  = 1'b1
  } hold_kind_e;
endpackage

// File: rtl/tlm_chan.sv
module tlm_chan #(
  parameter int                 DW    = 12,
  parameter int                 SHIFT = 2,
  parameter tlm_pkg::hold_kind_e KIND = tlm_pkg::KIND_PEAK
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic [DW-1:0] smp_i,
  input  logic [DW-1:0] limit_i,
  input  logic          rd_clr_i,
  input  logic          alert_clr_i,
  output logic [DW-1:0] avg_o,
  output logic [DW-1:0] hold_o,
  output logic          alert_o,
  output logic          alert_set_o
);
  localparam bit IS_MIN = (KIND == tlm_pkg::KIND_MIN);
  localparam logic [DW-1:0] IDLE = IS_MIN ? {DW{1'b1}} : {DW{1'b0}};

  logic [DW-1:0] avg_q, hold_q, base, hold_d, avg_d;
  logic          seeded_q, alert_q, better, cond;
  logic signed [DW:0] diff, step;

  always_comb begin
    base   = rd_clr_i ? IDLE : hold_q;
    better = IS_MIN ? (smp_i < base) : (smp_i > base);
    hold_d = (vld_i && better) ? smp_i : base;
    cond   = IS_MIN ? (hold_d < limit_i) : (hold_d > limit_i);
    diff   = $signed({1'b0, smp_i}) - $signed({1'b0, avg_q});
    step   = diff >>> SHIFT;
    avg_d  = seeded_q ? avg_q + step[DW-1:0] : smp_i;
  end

  assign alert_set_o = cond & ~alert_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      avg_q    <= '0;
      hold_q   <= IDLE;
      seeded_q <= 1'b0;
      alert_q  <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      alert_q <= cond | (alert_q & ~alert_clr_i);
      if (vld_i) begin
        avg_q    <= avg_d;
        seeded_q <= 1'b1;
      end
    end
  end

  assign avg_o   = avg_q;
  assign hold_o  = hold_q;
  assign alert_o = alert_q;

  a_r1_avg_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(avg_q));
  a_r4_alert_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alert_q && !alert_clr_i) |=> alert_q);
  generate
    if (IS_MIN) begin : g_min_chk
      a_r2_min_monotone: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_clr_i |=> hold_q <= $past(hold_q));
    end else begin : g_peak_chk
      a_r2_peak_monotone: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_clr_i |=> hold_q >= $past(hold_q));
    end
  endgenerate
endmodule

// File: rtl/tlm_log.sv
module tlm_log #(
  parameter int EW    = 90,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [EW-1:0]   data_i,
  input  logic            pop_i,
  input  logic            ovf_clr_i,
  output logic [EW-1:0]   data_o,
  output logic            valid_o,
  output logic [CNTW-1:0] count_o,
  output logic            ovf_o
);
  logic [EW-1:0]   mem_q [DEPTH];
  logic [AW-1:0]   rd_q, wr_q;
  logic [CNTW-1:0] cnt_q;
  logic            ovf_q, pop_ok, full, drop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pop_ok = pop_i && (cnt_q != '0);
  assign full   = (cnt_q == CNTW'(DEPTH));
  assign drop   = push_i && full && !pop_ok;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_ok || drop) rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CNTW'(push_i) - CNTW'(pop_ok | drop);
      ovf_q <= drop | (ovf_q & ~ovf_clr_i);
    end
  end

  assign data_o  = mem_q[rd_q];
  assign valid_o = (cnt_q != '0);
  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;

  a_r8_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNTW'(DEPTH));
  a_r8_empty_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !push_i) |=> cnt_q == '0);
  a_r9_ovf_on_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i) |=> ovf_q);
  a_r9_full_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i) |=> cnt_q == CNTW'(DEPTH));
endmodule

// File: rtl/tlm_snap_logger.sv
module tlm_snap_logger #(
  parameter int             NCH      = 5,
  parameter int             DW       = 12,
  parameter int             SHIFT    = 2,
  parameter logic [NCH-1:0] MIN_MASK = 5'b10100,
  parameter int             NF       = 4,
  parameter int             TW       = 2,
  parameter int             CW       = 8,
  parameter int             TSW      = 16,
  parameter int             DEPTH    = 4,
  localparam int            SELW     = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int            CNTW     = $clog2(DEPTH + 1),
  localparam int            EW       = TSW + NCH*DW + NF + CW + TW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    smp_vld_i,
  input  logic [NCH*DW-1:0] smp_i,
  input  logic [NCH*DW-1:0] limit_i,
  input  logic [NCH-1:0]    alert_clr_i,
  input  logic [NF-1:0]     fault_i,
  input  logic              err_evt_i,
  input  logic [TW-1:0]     lvl_i,
  input  logic              hold_rd_i,
  input  logic [SELW-1:0]   hold_sel_i,
  input  logic              log_pop_i,
  input  logic              ovf_clr_i,
  output logic [NCH*DW-1:0] avg_o,
  output logic [NCH-1:0]    alert_o,
  output logic [DW-1:0]     hold_o,
  output logic              log_valid_o,
  output logic [CNTW-1:0]   log_count_o,
  output logic              log_ovf_o,
  output logic [TSW-1:0]    log_ts_o,
  output logic [NCH*DW-1:0] log_hold_o,
  output logic [NF-1:0]     log_fault_o,
  output logic [CW-1:0]     log_err_o,
  output logic [TW-1:0]     log_lvl_o
);
  logic [NCH*DW-1:0] hold_all;
  logic [NCH-1:0]    alert_set;
  logic [NF-1:0]     fault_q;
  logic [TW-1:0]     lvl_q;
  logic [CW-1:0]     err_q;
  logic [TSW-1:0]    ts_q;
  logic [DW-1:0]     rd_val, hold_q;
  logic              trig_q, trig_d;
  logic [EW-1:0]     ent_in, ent_out;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tlm_chan #(
      .DW   (DW),
      .SHIFT(SHIFT),
      .KIND (tlm_pkg::hold_kind_e'(MIN_MASK[i]))
    ) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .vld_i      (smp_vld_i[i]),
      .smp_i      (smp_i[i*DW +: DW]),
      .limit_i    (limit_i[i*DW +: DW]),
      .rd_clr_i   (hold_rd_i && (hold_sel_i == SELW'(i))),
      .alert_clr_i(alert_clr_i[i]),
      .avg_o      (avg_o[i*DW +: DW]),
      .hold_o     (hold_all[i*DW +: DW]),
      .alert_o    (alert_o[i]),
      .alert_set_o(alert_set[i])
    );
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NCH; i++)
      if (hold_sel_i == SELW'(i)) rd_val = hold_all[i*DW +: DW];
  end

  // snapshot cause: new alert, fault rising edge, throttle step
  assign trig_d = (|alert_set) || (|(fault_i & ~fault_q)) || (lvl_i != lvl_q);
  assign ent_in = {ts_q, hold_all, fault_q, err_q, lvl_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= '0;
      lvl_q   <= '0;
      err_q   <= '0;
      ts_q    <= '0;
      trig_q  <= 1'b0;
      hold_q  <= '0;
    end else begin
      fault_q <= fault_i;
      lvl_q   <= lvl_i;
      ts_q    <= ts_q + 1'b1;
      trig_q  <= trig_d;
      if (err_evt_i && err_q != {CW{1'b1}}) err_q <= err_q + 1'b1;
      if (hold_rd_i) hold_q <= rd_val;
    end
  end

  tlm_log #(.EW(EW), .DEPTH(DEPTH)) u_log (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (trig_q),
    .data_i   (ent_in),
    .pop_i    (log_pop_i),
    .ovf_clr_i(ovf_clr_i),
    .data_o   (ent_out),
    .valid_o  (log_valid_o),
    .count_o  (log_count_o),
    .ovf_o    (log_ovf_o)
  );

  assign {log_ts_o, log_hold_o, log_fault_o, log_err_o, log_lvl_o} = ent_out;
  assign hold_o = hold_q;

  a_r5_fault_trig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(fault_i & ~fault_q)) |=> trig_q);
  a_r5_lvl_trig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i != lvl_q) |=> trig_q);
  a_r7_err_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q == {CW{1'b1}}) |=> err_q == {CW{1'b1}});
  a_r6_ts_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ts_q == $past(ts_q) + 1'b1);
endmodule

// File: tb/tlm_snap_logger_tb_top.sv
module tlm_snap_logger_tb_top;
  localparam int NCH = 5, DW = 12, SHIFT = 2, NF = 4, TW = 2, CW = 8, TSW = 16, DEPTH = 4;
  localparam logic [NCH-1:0] MASK = 5'b10100;

  typedef struct packed {
    logic [TSW-1:0]    ts;
    logic [NCH*DW-1:0] h;
    logic [NF-1:0]     f;
    logic [CW-1:0]     e;
    logic [TW-1:0]     l;
  } ent_t;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NCH-1:0] vld = '0, aclr = '0, alert;
  logic [NCH*DW-1:0] smp = '0, lim = '0, avg, lhold;
  logic [NF-1:0] flt = '0, lfault;
  logic err = 1'b0, hrd = 1'b0, pop = 1'b0, oclr = 1'b0, lvalid, lovf;
  logic [TW-1:0] lvl = '0, llvl;
  logic [2:0] hsel = '0;
  logic [DW-1:0] hold;
  logic [2:0] lcnt;
  logic [TSW-1:0] lts;
  logic [CW-1:0] lerr;

  tlm_snap_logger dut_i (
    .clk_i(clk), .rst_ni(rst_n), .smp_vld_i(vld), .smp_i(smp), .limit_i(lim),
    .alert_clr_i(aclr), .fault_i(flt), .err_evt_i(err), .lvl_i(lvl),
    .hold_rd_i(hrd), .hold_sel_i(hsel), .log_pop_i(pop), .ovf_clr_i(oclr),
    .avg_o(avg), .alert_o(alert), .hold_o(hold), .log_valid_o(lvalid),
    .log_count_o(lcnt), .log_ovf_o(lovf), .log_ts_o(lts), .log_hold_o(lhold),
    .log_fault_o(lfault), .log_err_o(lerr), .log_lvl_o(llvl)
  );

  int nvec = 0, nfail = 0;
  bit done = 0;

  // reference state
  logic [DW-1:0] m_avg[NCH], m_hold[NCH], m_hold_o;
  logic [NCH-1:0] m_seed, m_alert;
  logic [NF-1:0] m_fault;
  logic [TW-1:0] m_lvl;
  logic [CW-1:0] m_err;
  logic [TSW-1:0] m_ts;
  logic m_trig, m_ovf;
  ent_t mq[$];

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nvec++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] ident(input int i);
    return MASK[i] ? {DW{1'b1}} : {DW{1'b0}};
  endfunction

  task automatic model_init();
    for (int i = 0; i < NCH; i++) begin m_avg[i] = '0; m_hold[i] = ident(i); end
    m_seed = '0; m_alert = '0; m_fault = '0; m_lvl = '0; m_err = '0; m_ts = '0;
    m_trig = 0; m_ovf = 0; m_hold_o = '0; mq.delete();
  endtask

  task automatic model_edge();
    ent_t e;
    logic drop, c;
    logic [NCH-1:0] aset;
    logic [DW-1:0] base, hn, s, lm;
    int d;
    drop = 0;
    if (pop && mq.size() > 0) void'(mq.pop_front());
    if (m_trig) begin
      e.ts = m_ts; e.f = m_fault; e.e = m_err; e.l = m_lvl;
      for (int i = 0; i < NCH; i++) e.h[i*DW +: DW] = m_hold[i];
      if (mq.size() == DEPTH) begin void'(mq.pop_front()); drop = 1; end
      mq.push_back(e);
    end
    m_ovf = drop | (m_ovf & !oclr);
    if (hrd) m_hold_o = (hsel < NCH) ? m_hold[hsel] : '0;
    aset = '0;
    for (int i = 0; i < NCH; i++) begin
      s = smp[i*DW +: DW]; lm = lim[i*DW +: DW];
      base = (hrd && hsel == 3'(i)) ? ident(i) : m_hold[i];
      hn = base;
      if (vld[i] && (MASK[i] ? s < base : s > base)) hn = s;
      c = MASK[i] ? (hn < lm) : (hn > lm);
      aset[i] = c & !m_alert[i];
      m_alert[i] = c | (m_alert[i] & !aclr[i]);
      m_hold[i] = hn;
      if (vld[i]) begin
        if (!m_seed[i]) m_avg[i] = s;
        else begin
          d = int'(s) - int'(m_avg[i]);
          d = d >>> SHIFT;
          m_avg[i] = DW'(int'(m_avg[i]) + d);
        end
        m_seed[i] = 1;
      end
    end
    m_trig = (|aset) || (|(flt & ~m_fault)) || (lvl != m_lvl);
    m_fault = flt; m_lvl = lvl;
    if (err && m_err != 8'hFF) m_err++;
    m_ts++;
  endtask

  task automatic compare();
    logic [NCH*DW-1:0] ea;
    for (int i = 0; i < NCH; i++) ea[i*DW +: DW] = m_avg[i];
    chk("R1 averages", 64'(avg), 64'(ea));
    chk("R4 alerts", 64'(alert), 64'(m_alert));
    chk("R2 R3 hold read", 64'(hold), 64'(m_hold_o));
    chk("R5 R8 log count", 64'(lcnt), 64'(mq.size()));
    chk("R8 log valid", 64'(lvalid), 64'(mq.size() > 0));
    chk("R9 overflow", 64'(lovf), 64'(m_ovf));
    if (mq.size() > 0) begin
      chk("R6 entry timestamp", 64'(lts), 64'(mq[0].ts));
      chk("R6 entry holds", 64'(lhold), 64'(mq[0].h));
      chk("R6 entry fault/level", 64'({lfault, llvl}), 64'({mq[0].f, mq[0].l}));
      chk("R7 entry error count", 64'(lerr), 64'(mq[0].e));
    end
  endtask

  // inputs set at negedge; model advances for the coming posedge
  task automatic step();
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic quiet();
    vld = '0; aclr = '0; err = 0; hrd = 0; pop = 0; oclr = 0;
  endtask

  task automatic put(input int ch, input int v);
    vld[ch] = 1'b1; smp[ch*DW +: DW] = DW'(v);
  endtask

  initial begin
    void'($urandom(32'd20251));
    model_init();
    for (int i = 0; i < NCH; i++) lim[i*DW +: DW] = MASK[i] ? '0 : {DW{1'b1}};
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset avg", 64'(avg), 64'd0);
    chk("R10 reset alerts", 64'(alert), 64'd0);
    chk("R10 reset count/ovf/hold", 64'({lcnt, lovf, hold}), 64'd0);
    rst_n = 1'b1;

    // R1 seeding then EMA
    quiet(); put(0, 100); step();
    chk("R1 first sample seeds", 64'(avg[11:0]), 64'd100);
    quiet(); put(0, 200); step();
    chk("R1 ema step", 64'(avg[11:0]), 64'd125);
    quiet(); step();
    chk("R1 no strobe holds", 64'(avg[11:0]), 64'd125);

    // R2/R3 peak and min hold with clear-on-read
    quiet(); put(3, 50); step();
    quiet(); put(3, 300); step();
    quiet(); put(3, 20); put(2, 500); step();
    quiet(); put(2, 400); step();
    quiet(); hrd = 1; hsel = 3; step();
    chk("R3 peak read", 64'(hold), 64'd300);
    quiet(); hrd = 1; hsel = 3; step();
    chk("R3 peak restarted", 64'(hold), 64'd0);
    quiet(); hrd = 1; hsel = 2; step();
    chk("R2 min read", 64'(hold), 64'd400);
    quiet(); hrd = 1; hsel = 2; put(2, 900); step();
    chk("R2 min restarted", 64'(hold), 64'hFFF);
    quiet(); hrd = 1; hsel = 2; step();
    chk("R3 same-edge sample kept", 64'(hold), 64'd900);
    quiet(); hrd = 1; hsel = 7; step();
    chk("R3 bad channel", 64'(hold), 64'd0);

    // R4 latched alert and R5 snapshot
    quiet(); lim[1*DW +: DW] = 12'd1000; put(1, 1001); step();
    chk("R4 alert set", 64'(alert[1]), 64'd1);
    quiet(); step();
    chk("R5 alert snapshot", 64'(lcnt), 64'd1);
    quiet(); aclr[1] = 1; step();
    chk("R4 clear ignored while above", 64'(alert[1]), 64'd1);
    quiet(); hrd = 1; hsel = 1; step();
    quiet(); aclr[1] = 1; step();
    chk("R4 clear after read", 64'(alert[1]), 64'd0);
    lim[1*DW +: DW] = {DW{1'b1}};
    quiet(); flt = 4'b0010; step();
    quiet(); step();
    chk("R5 fault snapshot", 64'(lcnt), 64'd2);
    chk("R6 first entry holds ch1", 64'(lhold[1*DW +: DW]), 64'd1001);

    // R9 overflow, R8 drain
    for (int k = 0; k < 6; k++) begin quiet(); lvl = TW'(k + 1); step(); end
    quiet(); step(); quiet(); step();
    chk("R9 full count", 64'(lcnt), 64'd4);
    chk("R9 overflow set", 64'(lovf), 64'd1);
    quiet(); oclr = 1; step();
    chk("R9 overflow cleared", 64'(lovf), 64'd0);
    for (int k = 0; k < 6; k++) begin quiet(); pop = 1; step(); end
    chk("R8 drained and empty pop", 64'(lcnt), 64'd0);

    // R7 saturation
    for (int k = 0; k < 300; k++) begin quiet(); err = 1; step(); end
    quiet(); lvl = lvl + 1'b1; step(); quiet(); step();
    chk("R7 saturated count", 64'(lerr), 64'hFF);

    // constrained random
    for (int i = 0; i < NCH; i++)
      lim[i*DW +: DW] = MASK[i] ? 12'd300 : 12'd3800;
    for (int k = 0; k < 5000; k++) begin
      quiet();
      for (int i = 0; i < NCH; i++) begin
        if ($urandom_range(0, (i == 3 || i == 4) ? 3 : 7) == 0)
          put(i, int'($urandom_range(0, 4095)));
        if ($urandom_range(0, 15) == 0) aclr[i] = 1;
      end
      if ($urandom_range(0, 7) == 0) begin hrd = 1; hsel = 3'($urandom_range(0, 5)); end
      if ($urandom_range(0, 40) == 0) flt = NF'($urandom);
      if ($urandom_range(0, 60) == 0) lvl = TW'($urandom);
      err = ($urandom_range(0, 3) == 0);
      pop = ($urandom_range(0, 2) == 0);
      oclr = ($urandom_range(0, 30) == 0);
      step();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule